// File: doc/BRIEF.md
# Streaming Modified Adler Checksum Engine

This block computes a two-part 32-bit checksum over a packet that arrives as a stream of 16-bit words, one word per clock. It keeps a low sum (the running total of the words) and a high sum (the running total of the low sum after each word). Neither sum is reduced by a true modulo. Each is instead pulled back by one cheap conditional step that folds into 16 bits. In the prime variant this step adds 15 whenever the raw sum has reached 65521. In the ones-complement variant the low sum takes a +1 end-around step at 65535 and the high sum simply wraps.

A word is taken on every cycle in which `in_valid` and `in_ready` are both high. A word flagged start-of-packet clears both sums before it is added, and the variant is latched from `mode_sel` on that word. A word flagged end-of-packet makes the finished checksum appear on `sum_out` with a one-cycle `done` pulse in the next cycle. The folding step is only partial: raw residues from 65521 to 65535 land on 0 to 14 and cannot be told apart from them. The checksum therefore has those blind codes, and the block reproduces them exactly.

Top module: `cksum_stream`

## Requirements
- R1: When a start-of-packet word is accepted, both sums restart from zero and that word is added to the zero state. A single-word packet with word w < 65521 in prime mode gives `sum_out` = {w, w}.
- R2: In prime mode (`mode_sel`=0), the raw low sum is low + word, kept to 17 bits. If it is at least 65521, it becomes (raw + 15) mod 65536. Raw 65521+k (k = 0..14) therefore yields k.
- R3: After each word the high sum becomes high + new low. In prime mode the same conditional +15 fold at 65521 is then applied.
- R4: In ones-complement mode (`mode_sel`=1), a raw low sum of at least 65535 becomes (raw + 1) mod 65536, so 65535 aliases with 0. A finished low sum is never 0xFFFF in this mode.
- R5: In ones-complement mode the high sum is (high + new low) mod 65536, with no fold step.
- R6: The variant is sampled only on an accepted start-of-packet word. `mode_sel` on later words of the packet has no effect.
- R7: `done` is high for exactly the one cycle after an end-of-packet word is accepted, and low in every other cycle. `sum_out` then holds {high sum, low sum}, with the high sum in bits 31:16 and the low sum in bits 15:0.
- R8: A cycle with `in_valid` low leaves both sums and `sum_out` unchanged, whatever `in_sop`, `in_eop`, `in_data` and `mode_sel` hold.
- R9: After reset, `sum_out` is 0, `done` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Word on `in_data` is offered |
| in_ready | output | 1 | Engine takes a word this cycle |
| in_sop | input | 1 | Offered word starts a packet |
| in_eop | input | 1 | Offered word ends a packet |
| in_data | input | 16 | Data word |
| mode_sel | input | 1 | Variant: 0 prime fold, 1 ones-complement fold |
| sum_out | output | 32 | {high sum, low sum} |
| done | output | 1 | Single-cycle pulse: `sum_out` holds a finished checksum |

## Verification
Single-word packets near 65520, 65521, 65535 and 0xFFFF probe the fold thresholds directly. They separate a correct comparison from an off-by-one, and a 17-bit comparison from a truncated one. Two-word packets that land the raw sum on 65521+k show that the blind codes alias onto k. Long packets of words near 0xFFFF push the high sum across the fold in both variants, which separates folding from wrapping on the high side. Random packets mixed with idle cycles, stray flags on idle cycles, mode flips inside packets and back-to-back one-word packets test restart, mode latching, hold behaviour and the exact timing of `done`.

// File: rtl/cks_pkg.sv
package cks_pkg;
   typedef enum logic {
      CKS_PRIME = 1'b0,
      CKS_ONES  = 1'b1
   } cks_mode_e;
endpackage

// File: rtl/cks_fold.sv
// One accumulate step with the single-shot fold toward the modulus.
module cks_fold
   import cks_pkg::*;
#(
   parameter int W         = 16,
   parameter int PRIME     = 65521,
   parameter bit ONES_FOLD = 1'b1
) (
   input  logic [W-1:0] acc,
   input  logic [W-1:0] addend,
   input  cks_mode_e    mode,
   output logic [W-1:0] nxt
);
   localparam longint SPAN      = longint'(1) << W;
   localparam logic [W:0] P_LIM = (W+1)'(PRIME);
   localparam logic [W:0] P_ADJ = (W+1)'(SPAN - PRIME);
   localparam logic [W:0] O_LIM = (W+1)'(SPAN - 1);

   if (W < 2 || W > 31) begin : g_bad_w
      $error("cks_fold: W out of range");
   end
   if (PRIME < 2 || longint'(PRIME) >= SPAN) begin : g_bad_p
      $error("cks_fold: PRIME must lie below 2**W");
   end

   logic [W:0] raw;
   logic [W:0] prime_v;
   logic [W:0] ones_v;

   always_comb begin
      raw     = {1'b0, acc} + {1'b0, addend};
      prime_v = (raw >= P_LIM) ? raw + P_ADJ : raw;
   end

   if (ONES_FOLD) begin : g_ones_fold
      always_comb ones_v = (raw >= O_LIM) ? raw + {{W{1'b0}}, 1'b1} : raw;
   end else begin : g_ones_wrap
      always_comb ones_v = raw;
   end

   always_comb nxt = (mode == CKS_ONES) ? ones_v[W-1:0] : prime_v[W-1:0];
endmodule

// File: rtl/cks_accum.sv
// Low and high sum registers with restart on packet start.
module cks_accum
   import cks_pkg::*;
#(
   parameter int W     = 16,
   parameter int PRIME = 65521
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic         restart,
   input  logic [W-1:0] word,
   input  cks_mode_e    mode,
   output logic [W-1:0] lo,
   output logic [W-1:0] hi
);
   logic [W-1:0] lo_q, hi_q, lo_base, hi_base, lo_n, hi_n;

   always_comb begin
      lo_base = restart ? '0 : lo_q;
      hi_base = restart ? '0 : hi_q;
   end

   cks_fold #(.W(W), .PRIME(PRIME), .ONES_FOLD(1'b1)) u_lo (
      .acc(lo_base), .addend(word), .mode(mode), .nxt(lo_n)
   );

   cks_fold #(.W(W), .PRIME(PRIME), .ONES_FOLD(1'b0)) u_hi (
      .acc(hi_base), .addend(lo_n), .mode(mode), .nxt(hi_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else if (step) begin
         lo_q <= lo_n;
         hi_q <= hi_n;
      end
   end

   assign lo = lo_q;
   assign hi = hi_q;
endmodule

// File: rtl/cks_ctrl.sv
// Handshake, mode latch and completion pulse.
module cks_ctrl
   import cks_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      in_valid,
   input  logic      in_sop,
   input  logic      in_eop,
   input  logic      mode_in,
   output logic      ready,
   output logic      accept,
   output logic      restart,
   output cks_mode_e eff_mode,
   output cks_mode_e mode_q,
   output logic      done
);
   logic ready_q, done_q;
   cks_mode_e mode_r;

   always_comb begin
      accept   = in_valid && ready_q;
      restart  = accept && in_sop;
      eff_mode = restart ? cks_mode_e'(mode_in) : mode_r;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_q <= 1'b0;
         done_q  <= 1'b0;
         mode_r  <= CKS_PRIME;
      end else begin
         ready_q <= 1'b1;
         done_q  <= accept && in_eop;
         if (restart) mode_r <= cks_mode_e'(mode_in);
      end
   end

   assign ready  = ready_q;
   assign mode_q = mode_r;
   assign done   = done_q;
endmodule

// File: rtl/cksum_stream.sv
module cksum_stream
   import cks_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int PRIME  = 65521,
   localparam int SUM_W = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              in_sop,
   input  logic              in_eop,
   input  logic [DATA_W-1:0] in_data,
   input  logic              mode_sel,
   output logic [SUM_W-1:0]  sum_out,
   output logic              done
);
   logic      accept, restart;
   cks_mode_e eff_mode, mode_q;
   logic [DATA_W-1:0] lo, hi;

   cks_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
      .in_eop(in_eop), .mode_in(mode_sel), .ready(in_ready),
      .accept(accept), .restart(restart), .eff_mode(eff_mode),
      .mode_q(mode_q), .done(done)
   );

   cks_accum #(.W(DATA_W), .PRIME(PRIME)) u_acc (
      .clk(clk), .rst_n(rst_n), .step(accept), .restart(restart),
      .word(in_data), .mode(eff_mode), .lo(lo), .hi(hi)
   );

   assign sum_out = {hi, lo};
endmodule

// File: rtl/cksum_stream_chk.sv
module cksum_stream_chk #(
   parameter int DATA_W = 16,
   parameter int PRIME  = 65521
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic                in_ready,
   input logic                in_sop,
   input logic                in_eop,
   input logic [DATA_W-1:0]   in_data,
   input logic                mode_sel,
   input logic                mode_q,
   input logic [2*DATA_W-1:0] sum_out,
   input logic                done
);
   logic acc;
   assign acc = in_valid && in_ready;

   // R7
   done_after_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && in_eop) |=> done);

   // R7
   done_only_after_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc && in_eop) |=> !done);

   // R8
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(sum_out));

   // R1
   single_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && in_sop && in_eop && !mode_sel && in_data < DATA_W'(PRIME))
      |=> sum_out == {$past(in_data), $past(in_data)});

   // R4
   ones_low_never_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && mode_q) |-> sum_out[DATA_W-1:0] != {DATA_W{1'b1}});
endmodule

bind cksum_stream cksum_stream_chk #(.DATA_W(DATA_W), .PRIME(PRIME)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data), .mode_sel(mode_sel),
   .mode_q(mode_q), .sum_out(sum_out), .done(done)
);

// File: tb/cksum_stream_test.sv
`timescale 1ns/1ps
module cksum_stream_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, mode_sel = 1'b0;
   logic [15:0] in_data = '0;
   logic        in_ready, done;
   logic [31:0] sum_out;

   int total = 0, bad = 0;
   logic [31:0] model = '0;
   bit  pkt_mode = 1'b0;
   bit  finished = 1'b0;

   always #2.5 clk = ~clk;

   cksum_stream uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
      .mode_sel(mode_sel), .sum_out(sum_out), .done(done)
   );

   function automatic logic [31:0] ref_step(logic [31:0] st, logic [15:0] w, bit ones);
      int lo, hi;
      lo = int'(st[15:0]) + int'(w);
      if (!ones) begin
         if (lo >= 65521) lo = (lo + 15) % 65536;
      end else if (lo >= 65535) lo = (lo + 1) % 65536;
      hi = int'(st[31:16]) + lo;
      if (!ones) begin
         if (hi >= 65521) hi = (hi + 15) % 65536;
      end else hi = hi % 65536;
      return {hi[15:0], lo[15:0]};
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drive one word at a negedge; return at the next negedge and check done.
   task automatic send(logic [15:0] w, bit sop, bit eop, bit m, string req);
      in_valid = 1'b1; in_data = w; in_sop = sop; in_eop = eop; mode_sel = m;
      if (sop) begin model = '0; pkt_mode = m; end
      model = ref_step(model, w, pkt_mode);
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
      if (eop) begin
         check("R7 done", {31'd0, done}, 32'd1);
         check(req, sum_out, model);
      end else begin
         check("R7 no done", {31'd0, done}, 32'd0);
      end
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         in_valid = 1'b0; in_sop = $urandom_range(0, 1); in_eop = $urandom_range(0, 1);
         in_data = 16'($urandom); mode_sel = $urandom_range(0, 1);
         @(negedge clk);
         check("R8 hold", sum_out, model);
         check("R7 idle done", {31'd0, done}, 32'd0);
      end
      in_sop = 1'b0; in_eop = 1'b0;
   endtask

   initial begin
      #1_000_000;
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0b1d));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9
      check("R9 sum", sum_out, 32'd0);
      check("R9 done", {31'd0, done}, 32'd0);
      check("R9 ready", {31'd0, in_ready}, 32'd1);

      // R1 single word, below threshold
      send(16'd65520, 1, 1, 0, "R1 single 65520");
      // R2 raw 65521 aliases 0, raw 65535 aliases 14
      send(16'd65521, 1, 1, 0, "R2 single 65521");
      send(16'd65535, 1, 1, 0, "R2 single 65535");
      check("R2 blind 65535->14", {16'd0, sum_out[15:0]}, 32'd14);
      // R2 17-bit raw sum
      send(16'hFFF0, 1, 0, 0, "R2");
      send(16'hFFF0, 0, 1, 0, "R2 17-bit raw");
      // R2 blind code: 65000+521+k equals k
      for (int k = 0; k < 15; k += 7) begin
         send(16'd65000, 1, 0, 0, "R2");
         send(16'(521 + k), 0, 1, 0, "R2 blind alias");
         check("R2 blind low", {16'd0, sum_out[15:0]}, 32'(k));
      end
      // R4 ones mode aliasing
      send(16'hFFFF, 1, 1, 1, "R4 ones 0xFFFF");
      check("R4 ones 0xFFFF->0", sum_out, 32'd0);
      send(16'hFFFE, 1, 0, 1, "R4");
      send(16'h0002, 0, 1, 1, "R4 ones wrap");
      // R3 / R5 high sum across fold, both variants
      for (int m = 0; m < 2; m++) begin
         for (int i = 0; i < 8; i++)
            send(16'hFFF0 - 16'(i), i == 0, i == 7, bit'(m), m ? "R5 high wrap" : "R3 high fold");
      end
      // R6 mode flips inside packet
      send(16'h8000, 1, 0, 0, "R6");
      send(16'h9000, 0, 0, 1, "R6");
      send(16'hF000, 0, 1, 1, "R6 mode latched prime");
      send(16'h8000, 1, 0, 1, "R6");
      send(16'h9000, 0, 1, 0, "R6 mode latched ones");
      // R8 idle with stray flags
      idle(4);
      // R7 back-to-back single-word packets
      send(16'h1234, 1, 1, 0, "R7 b2b a");
      send(16'h4321, 1, 1, 1, "R7 b2b b");

      // random packets
      for (int p = 0; p < 60; p++) begin
         int len = $urandom_range(1, 24);
         bit m = $urandom_range(0, 1);
         for (int i = 0; i < len; i++) begin
            logic [15:0] w = ($urandom_range(0, 1) != 0) ? 16'(16'hFFFF - $urandom_range(0, 40))
                                                          : 16'($urandom);
            send(w, i == 0, i == len - 1, (i == 0) ? m : bit'($urandom_range(0, 1)),
                 m ? "R5 random ones" : "R3 random prime");
            if ($urandom_range(0, 3) == 0) idle(1);
         end
      end

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule